// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block turns a 36-bit physical bus address into one of four active-low chip-select lines. Each region has a configuration word that software reads and writes through a small register port. The word holds an enable, a 14-bit base field and a 14-bit mask field, both covering address bits 31:18. A region matches when it is enabled and the address, ANDed with the region's full-width mask, equals the region's full-width base.

The full-width mask is built from three parts: bits 35:32 are forced to ones, bits 31:18 come from the mask field, and bits 17:0 are zero. This gives 256 KB granularity. The full-width base is built from three parts as well: bits 35:32 come from that region's 4-bit device-type input, bits 31:18 come from the base field, and bits 17:0 are zero.

The decode result is registered. An address that is qualified by a valid strobe produces its chip select one clock later. Programmed regions should not overlap. If they do, the outcome is still deterministic: only the lowest-numbered match is driven, and a sticky flag records that an overlap happened. The 3-bit boot code decides at reset whether region 0 starts enabled.

Top module: `cs_region_decode`

## Requirements
- R1: While reset is held, every configuration word takes its reset value. Region 0 resets to base 0x7F0 and mask 0x3FFF. Regions 1 to 3 reset to base 0x3FFF and mask 0x3FFF, with the enable clear.
- R2: Region 0's enable resets to 1 when bit 2 of the boot code is 0, and to 0 when it is 1.
- R3: Each configuration word has the following layout. Bit 28 is the enable, bits 27:14 are the base field and bits 13:0 are the mask field. Bits 31:29 always read as zero, and writes to them are ignored. A write is visible on read data in the next cycle.
- R4: The words sit at offsets 0x1008, 0x1018, 0x1028 and 0x1038. A read at any other offset returns zero, and a write to any other offset changes no word.
- R5: A region matches when all three of these hold: its enable is 1; address bits 35:32 equal its device-type input; and address bits 31:18, ANDed with the mask field, equal the base field. Address bits 17:0 are ignored.
- R6: A disabled region never drives its chip select low.
- R7: Chip-select outputs are registered. They reflect the address and valid strobe that were present at the previous rising edge. All outputs are high after a cycle in which valid was low, and all are high during reset.
- R8: When several regions match, only the lowest-numbered one is driven low. At most one output is ever low.
- R9: The overlap flag is cleared by reset. It goes high one cycle after a valid address matches more than one region, and it stays high until the next reset.
- R10: Region i's device type comes from bits 4i+3:4i of the device-type input. Changing those bits moves region i to a different 4 GB window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bootCode | input | 3 | Boot mode; sets region 0's enable at reset |
| devType | input | 16 | Four 4-bit device types, region i at bits 4i+3:4i |
| regAddr | input | 16 | Register port byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| busAddr | input | 36 | Physical bus address |
| busValid | input | 1 | Qualifies busAddr for decoding |
| csN | output | 4 | Active-low chip selects, registered |
| overlapSeen | output | 1 | Sticky flag: a valid address hit more than one region |

## Verification
The assertions assume that reset is held low for at least one rising edge, so that every configuration register and output register is loaded before checking starts. They place no condition on region overlap. The at-most-one-low and sticky-flag properties must hold under any programming, and the stimulus deliberately copies one region's base into another to create overlaps. Random addresses are built from a chosen region's base with random don't-care bits filled in, so matches are frequent. Device types and the valid strobe are re-randomised only at the inactive clock edge.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;
  parameter int CsCount   = 4;
  parameter int FieldW    = 14;
  parameter int PhysAddrW = 36;
  parameter int TypeW     = 4;
  parameter int LowZeroW  = 18;
  parameter int RegW      = 32;
  parameter int EnBit     = FieldW * 2;

  // control -> datapath: current decode configuration
  typedef struct packed {
    logic [CsCount-1:0]             en;
    logic [CsCount-1:0][FieldW-1:0] base;
    logic [CsCount-1:0][FieldW-1:0] mask;
  } cs_cfg_t;
endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import cs_decode_pkg::*;
#(
  parameter int          RegAddrW      = 16,
  parameter int          FirstOffset   = 'h1008,
  parameter int          Stride        = 'h10,
  parameter int          BootW         = 3,
  parameter logic        BootStaticMsb = 1'b0,
  parameter logic [13:0] Cs0BaseRst    = 14'h07F0,
  parameter logic [13:0] BaseRst       = 14'h3FFF,
  parameter logic [13:0] MaskRst       = 14'h3FFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BootW-1:0]    bootCode,
  input  logic [RegAddrW-1:0] regAddr,
  input  logic                regWrEn,
  input  logic [RegW-1:0]     regWrData,
  output logic [RegW-1:0]     regRdData,
  output cs_cfg_t             cfg
);
  logic [CsCount-1:0] hit;
  logic               bootEn;
  logic               unusedCtrl;

  assign bootEn     = (bootCode[BootW-1] == BootStaticMsb);
  assign unusedCtrl = ^{regWrData[RegW-1:EnBit+1], bootCode[BootW-2:0]};

  for (genvar i = 0; i < CsCount; i++) begin : g_hit
    assign hit[i] = (regAddr == RegAddrW'(FirstOffset + i * Stride));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CsCount; i++) begin
        cfg.en[i]   <= (i == 0) ? bootEn : 1'b0;
        cfg.base[i] <= (i == 0) ? Cs0BaseRst : BaseRst;
        cfg.mask[i] <= MaskRst;
      end
    end else if (regWrEn) begin
      for (int i = 0; i < CsCount; i++) begin
        if (hit[i]) begin
          cfg.en[i]   <= regWrData[EnBit];
          cfg.base[i] <= regWrData[EnBit-1 -: FieldW];
          cfg.mask[i] <= regWrData[FieldW-1:0];
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < CsCount; i++) begin
      if (hit[i]) begin
        regRdData[EnBit]              = cfg.en[i];
        regRdData[EnBit-1 -: FieldW]  = cfg.base[i];
        regRdData[FieldW-1:0]         = cfg.mask[i];
      end
    end
  end
endmodule

// File: rtl/cs_match_path.sv
module cs_match_path
  import cs_decode_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  cs_cfg_t                    cfg,
  input  logic [CsCount*TypeW-1:0]   devType,
  input  logic [PhysAddrW-1:0]       busAddr,
  input  logic                       busValid,
  output logic [CsCount-1:0]         csN,
  output logic                       overlapSeen
);
  logic [CsCount-1:0] match;
  logic [CsCount-1:0] pick;
  logic               multiHit;
  logic               unusedLow;

  assign unusedLow = ^busAddr[LowZeroW-1:0];

  for (genvar i = 0; i < CsCount; i++) begin : g_match
    logic typeOk;
    logic fieldOk;
    assign typeOk   = (busAddr[PhysAddrW-1 -: TypeW] == devType[i*TypeW +: TypeW]);
    assign fieldOk  = ((busAddr[LowZeroW +: FieldW] & cfg.mask[i]) == cfg.base[i]);
    assign match[i] = cfg.en[i] & typeOk & fieldOk;
  end

  // lowest set bit wins
  assign pick     = match & (~match + CsCount'(1));
  assign multiHit = |(match & (match - CsCount'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN         <= '1;
      overlapSeen <= 1'b0;
    end else begin
      csN         <= busValid ? ~pick : '1;
      overlapSeen <= overlapSeen | (busValid & multiHit);
    end
  end
endmodule

// File: rtl/cs_region_decode.sv
module cs_region_decode
  import cs_decode_pkg::*;
#(
  parameter int   RegAddrW      = 16,
  parameter int   FirstOffset   = 'h1008,
  parameter int   Stride        = 'h10,
  parameter int   BootW         = 3,
  parameter logic BootStaticMsb = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [BootW-1:0]         bootCode,
  input  logic [CsCount*TypeW-1:0] devType,
  input  logic [RegAddrW-1:0]      regAddr,
  input  logic                     regWrEn,
  input  logic [RegW-1:0]          regWrData,
  output logic [RegW-1:0]          regRdData,
  input  logic [PhysAddrW-1:0]     busAddr,
  input  logic                     busValid,
  output logic [CsCount-1:0]       csN,
  output logic                     overlapSeen
);
  cs_cfg_t cfgBus;

  cs_cfg_bank #(
    .RegAddrW(RegAddrW), .FirstOffset(FirstOffset), .Stride(Stride),
    .BootW(BootW), .BootStaticMsb(BootStaticMsb)
  ) u_bank (
    .clk(clk), .rstN(rstN), .bootCode(bootCode), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cfg(cfgBus)
  );

  cs_match_path u_path (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .devType(devType),
    .busAddr(busAddr), .busValid(busValid), .csN(csN),
    .overlapSeen(overlapSeen)
  );
endmodule

// File: rtl/cs_region_decode_chk.sv
module cs_region_decode_chk
  import cs_decode_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic [CsCount-1:0] csN,
  input logic               overlapSeen,
  input logic [2:0]         rsvdRd,
  input logic [CsCount-1:0] enVec
);
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R7
  cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busValid) |-> (csN == '1));

  // R6
  cs_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~csN) & ~$past(enVec)) == '0);

  // R9
  overlap_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(overlapSeen) |-> overlapSeen);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsvdRd == 3'b000);
endmodule

bind cs_region_decode cs_region_decode_chk u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .csN(csN),
  .overlapSeen(overlapSeen), .rsvdRd(regRdData[31:29]), .enVec(cfgBus.en)
);

// File: tb/cs_region_decode_tb.sv
module cs_region_decode_tb;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  bootCode;
  logic [15:0] devType;
  logic [15:0] regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [35:0] busAddr;
  logic        busValid;
  logic [3:0]  csN;
  logic        overlapSeen;

  int checks = 0;
  int failures = 0;

  logic        shEn[4];
  logic [13:0] shBase[4];
  logic [13:0] shMask[4];
  logic        expOv;

  always #(ClkPeriod/2) clk = ~clk;

  cs_region_decode u_dut (
    .clk(clk), .rstN(rstN), .bootCode(bootCode), .devType(devType),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .busAddr(busAddr), .busValid(busValid),
    .csN(csN), .overlapSeen(overlapSeen)
  );

  function automatic logic [15:0] offOf(input int r);
    return 16'(32'h1008 + r * 32'h10);
  endfunction

  function automatic logic [31:0] wordOf(input int r);
    return {3'b000, shEn[r], shBase[r], shMask[r]};
  endfunction

  function automatic logic [3:0] matchOf(input logic [35:0] a);
    logic [3:0] m;
    for (int r = 0; r < 4; r++)
      m[r] = shEn[r] && (a[35:32] == devType[4*r +: 4]) &&
             ((a[31:18] & shMask[r]) == shBase[r]);
    return m;
  endfunction

  function automatic logic [3:0] expCs(input logic [3:0] m, input logic v);
    if (!v) return 4'hF;
    for (int r = 0; r < 4; r++) if (m[r]) return ~(4'b1 << r);
    return 4'hF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] boot);
    @(negedge clk);
    rstN = 1'b0; bootCode = boot; busValid = 1'b0; regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < 4; r++) begin
      shEn[r] = (r == 0) ? (boot[2] == 1'b0) : 1'b0;
      shBase[r] = (r == 0) ? 14'h07F0 : 14'h3FFF;
      shMask[r] = 14'h3FFF;
    end
    expOv = 1'b0;
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic decode(input logic [35:0] a, input logic v, input string req);
    logic [3:0] m;
    @(negedge clk);
    busAddr = a; busValid = v;
    m = matchOf(a);
    if (v && ((m & (m - 4'd1)) != 4'd0)) expOv = 1'b1;
    @(negedge clk);
    check(req, {28'd0, csN}, {28'd0, expCs(m, v)});
    check("R9 flag", {31'd0, overlapSeen}, {31'd0, expOv});
    busValid = 1'b0;
  endtask

  task automatic checkAllRegs(input string req);
    logic [31:0] d;
    for (int r = 0; r < 4; r++) begin
      regRead(offOf(r), d);
      check(req, d, wordOf(r));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unused = $urandom(32'h00C5_1DEC);
    rstN = 1'b0; bootCode = 3'b000; regAddr = '0; regWrEn = 1'b0;
    regWrData = '0; busAddr = '0; busValid = 1'b0;
    devType = 16'hA5C3;

    // R1 R2: reset with boot-from-static code
    doReset(3'b011);
    check("R7 reset idle", {28'd0, csN}, 32'hF);
    check("R9 reset clear", {31'd0, overlapSeen}, 32'd0);
    regRead(16'h1008, d);
    check("R2 cs0 enabled", d, 32'h1000_0000 | (32'h7F0 << 14) | 32'h3FFF);
    checkAllRegs("R1 reset words");
    decode({devType[3:0], 14'h07F0, 18'h2ABCD}, 1'b1, "R5 R2 boot region");
    decode({devType[3:0], 14'h07F0, 18'h2ABCD}, 1'b0, "R7 valid low");
    decode({4'h9, 14'h07F0, 18'h00001}, 1'b1, "R10 wrong type");
    decode({devType[3:0], 14'h07F1, 18'h0}, 1'b1, "R5 base miss");

    // R2: other boot code leaves cs0 disabled
    doReset(3'b100);
    regRead(16'h1008, d);
    check("R2 cs0 disabled", d, (32'h7F0 << 14) | 32'h3FFF);
    decode({devType[3:0], 14'h07F0, 18'h0}, 1'b1, "R6 disabled cs0");

    // R4: unmapped offsets
    regWrite(16'h1010, 32'hFFFF_FFFF);
    regWrite(16'h1009, 32'hFFFF_FFFF);
    regRead(16'h1010, d);
    check("R4 unmapped read", d, 32'd0);
    regRead(16'h1048, d);
    check("R4 unmapped read", d, 32'd0);
    checkAllRegs("R4 unmapped write");

    // R3: reserved bits dropped
    regWrite(offOf(1), 32'hFFFF_FFFF);
    shEn[1] = 1'b1; shBase[1] = 14'h3FFF; shMask[1] = 14'h3FFF;
    regRead(offOf(1), d);
    check("R3 reserved ignored", d, 32'h1FFF_FFFF);

    // R8 R9: directed overlap of regions 1 and 2
    devType = 16'h7777;
    regWrite(offOf(1), {3'b0, 1'b1, 14'h0100, 14'h3F00});
    regWrite(offOf(2), {3'b0, 1'b1, 14'h0100, 14'h3F00});
    shEn[1] = 1'b1; shBase[1] = 14'h0100; shMask[1] = 14'h3F00;
    shEn[2] = 1'b1; shBase[2] = 14'h0100; shMask[2] = 14'h3F00;
    decode({4'h7, 14'h0100, 18'h0}, 1'b1, "R8 overlap priority");
    decode({4'h7, 14'h0145, 18'h3FFFF}, 1'b1, "R8 overlap mask");
    check("R9 set", {31'd0, overlapSeen}, 32'd1);
    regWrite(offOf(2), {3'b0, 1'b1, 14'h0200, 14'h3F00});
    shBase[2] = 14'h0200;
    decode({4'h7, 14'h0200, 18'h0}, 1'b1, "R5 single match");
    check("R9 sticky", {31'd0, overlapSeen}, 32'd1);

    // constrained random
    doReset(3'b000);
    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 4;
      if (($urandom % 4) == 0) begin
        logic [13:0] mk = 14'h3FFF ^ 14'($urandom & 32'h3F);
        logic [13:0] bs = ($urandom % 3 == 0) ? shBase[$urandom % 4] : 14'($urandom) & mk;
        logic        en = ($urandom % 5) != 0;
        logic [2:0]  rs = 3'($urandom);
        regWrite(offOf(r), {rs, en, bs, mk});
        shEn[r] = en; shBase[r] = bs; shMask[r] = mk;
        regRead(offOf(r), d);
        check("R3 readback", d, wordOf(r));
      end
      if (($urandom % 16) == 0) devType = 16'($urandom);
      begin
        logic [3:0]  ty  = ($urandom % 6 == 0) ? 4'($urandom) : devType[4*r +: 4];
        logic [13:0] mid = shBase[r] | (14'($urandom) & ~shMask[r]);
        logic        v   = ($urandom % 5) != 0;
        decode({ty, mid, 18'($urandom)}, v, "R5 R8 R10 random");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule